// File: doc/BRIEF.md
# Dual-Order Wraparound Burst Address Generator

This block produces the array address for a four-beat burst. When the surrounding control logic accepts an address strobe, it pulses `load_i`. The block then captures the full incoming address. The low two bits become the start of a burst offset counter, and the remaining upper bits are held in a register. On each later clock edge where the active-low advance input is asserted, the offset moves to the next beat. When advance is released, the offset stays where it is, which suspends the burst.

A static selection input chooses the beat order. Driven low, it gives a linear order: the start value plus the beat number, modulo four. Driven high, it gives an interleaved order: the start value XOR the beat number. The counter wraps after the fourth beat. A new load in the middle of a burst starts a fresh burst from the new base address. Strobe priority and chip-enable qualification belong to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released with no other activity, `burst_ofs_o` is 0 and `array_addr_o` is 0.
- R2: After a clock edge with `load_i` high, `burst_ofs_o` equals the sampled `addr_i[1:0]` and `array_addr_o[ADDR_W-1:2]` equals the sampled `addr_i[ADDR_W-1:2]`.
- R3: With `seq_sel_i` = 1 (interleaved), beat k of a burst starting at S has offset S XOR k. For example, 10 gives 10, 11, 00, 01.
- R4: With `seq_sel_i` = 0 (linear), beat k of a burst starting at S has offset (S + k) mod 4. For example, 11 gives 11, 00, 01, 10.
- R5: A clock edge with `load_i` low and `adv_n_i` high leaves `burst_ofs_o` unchanged.
- R6: The fourth advance after a load returns the offset to the start value.
- R7: When `load_i` is high and `adv_n_i` is low at the same edge, the load wins and the offset equals the loaded start.
- R8: Edges without `load_i` leave `array_addr_o[ADDR_W-1:2]` unchanged, whatever is on `addr_i`.
- R9: A load during a partly completed burst restarts the sequence at beat 0 from the new base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Accepted address strobe; captures `addr_i` |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| seq_sel_i | input | 1 | Order select: 0 linear, 1 interleaved (static) |
| addr_i | input | ADDR_W | Incoming address |
| burst_ofs_o | output | CNT_W | Current burst offset |
| array_addr_o | output | ADDR_W | Upper address register concatenated with the offset |

## Verification
Every load, advance or hold takes effect at the clock edge that samples it, so its result is due one edge after the inputs are driven. The driver applies inputs on the falling edge and pushes the expected offset and full address into a queue at the same time. The monitor pops that entry 2 ns after the next rising edge and compares it. The order select acts combinationally on registered state, but the bench changes it only together with a load, so each expected value already reflects the order that applies.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic {
      SEQ_LINEAR     = 1'b0,
      SEQ_INTERLEAVE = 1'b1
   } seq_mode_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] start_d_i,
   output logic [CNT_W-1:0] start_q_o,
   output logic [CNT_W-1:0] beat_q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q_o <= '0;
         beat_q_o  <= '0;
      end else if (load_i) begin
         start_q_o <= start_d_i;
         beat_q_o  <= '0;
      end else if (step_i) begin
         beat_q_o  <= beat_q_o + 1'b1;
      end
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             seq_sel_i,
   input  logic [CNT_W-1:0] start_i,
   input  logic [CNT_W-1:0] beat_i,
   output logic [CNT_W-1:0] ofs_o
);
   logic [CNT_W-1:0] ilv_ofs;
   logic [CNT_W-1:0] lin_ofs;
   seq_mode_e        mode;

   assign mode = seq_mode_e'(seq_sel_i);

   for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
      assign ilv_ofs[b] = start_i[b] ^ beat_i[b];
   end

   assign lin_ofs = start_i + beat_i;

   always_comb begin
      unique case (mode)
         SEQ_INTERLEAVE: ofs_o = ilv_ofs;
         default:        ofs_o = lin_ofs;
      endcase
   end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int UP_W = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [UP_W-1:0] up_d_i,
   output logic [UP_W-1:0] up_q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      up_q_o <= '0;
      else if (load_i) up_q_o <= up_d_i;
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int ADDR_W = 17,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_n_i,
   input  logic              seq_sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [CNT_W-1:0]  burst_ofs_o,
   output logic [ADDR_W-1:0] array_addr_o
);
   localparam int UP_W = ADDR_W - CNT_W;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("burst_addr_gen: CNT_W must be at least 1");
   end
   if (UP_W < 1) begin : g_bad_addr
      $error("burst_addr_gen: ADDR_W must exceed CNT_W");
   end

   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] beat_q;
   logic [UP_W-1:0]  upper_q;

   burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .step_i    (!adv_n_i),
      .start_d_i (addr_i[CNT_W-1:0]),
      .start_q_o (start_q),
      .beat_q_o  (beat_q)
   );

   burst_order_map #(.CNT_W(CNT_W)) u_map (
      .seq_sel_i (seq_sel_i),
      .start_i   (start_q),
      .beat_i    (beat_q),
      .ofs_o     (burst_ofs_o)
   );

   burst_base_reg #(.UP_W(UP_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .up_d_i (addr_i[ADDR_W-1:CNT_W]),
      .up_q_o (upper_q)
   );

   assign array_addr_o = {upper_q, burst_ofs_o};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 17,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic              adv_n_i,
   input logic              seq_sel_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [CNT_W-1:0]  burst_ofs_o,
   input logic [ADDR_W-1:0] array_addr_o
);
   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> burst_ofs_o == $past(addr_i[CNT_W-1:0])); // R2
   AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n_i) |=> ($stable(burst_ofs_o) || seq_sel_i != $past(seq_sel_i))); // R5
   AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(array_addr_o[ADDR_W-1:CNT_W])); // R8
   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && !seq_sel_i) |=>
         (seq_sel_i || burst_ofs_o == CNT_W'($past(burst_ofs_o) + 1'b1))); // R4
   AST_STEP_LSB_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i) |=>
         (burst_ofs_o[0] != $past(burst_ofs_o[0]) || seq_sel_i != $past(seq_sel_i))); // R3
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .load_i       (load_i),
   .adv_n_i      (adv_n_i),
   .seq_sel_i    (seq_sel_i),
   .addr_i       (addr_i),
   .burst_ofs_o  (burst_ofs_o),
   .array_addr_o (array_addr_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic          adv_n_i = 1'b1;
   logic          seq_sel_i = 1'b1;
   logic [AW-1:0] addr_i = '0;
   logic [1:0]    burst_ofs_o;
   logic [AW-1:0] array_addr_o;

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic [1:0]    ofs;
      logic [AW-1:0] full;
      string         tag;
   } exp_t;
   exp_t sb_q[$];

   logic [1:0]    m_start = '0;
   logic [1:0]    m_beat = '0;
   logic [AW-3:0] m_upper = '0;

   always #5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .adv_n_i      (adv_n_i),
      .seq_sel_i    (seq_sel_i),
      .addr_i       (addr_i),
      .burst_ofs_o  (burst_ofs_o),
      .array_addr_o (array_addr_o)
   );

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic check(input string tag, input logic [1:0] exp_ofs, input logic [AW-1:0] exp_full);
      checks++;
      if (burst_ofs_o !== exp_ofs || array_addr_o !== exp_full) begin
         errors++;
         $display("FAIL %s: ofs=%b addr=%h expected ofs=%b addr=%h",
                  tag, burst_ofs_o, array_addr_o, exp_ofs, exp_full);
      end
   endtask

   // Driver: apply one cycle of stimulus and push the value due after the next edge
   task automatic drive(input logic ld, input logic advn, input logic [AW-1:0] a,
                        input logic mode, input string tag);
      exp_t e;
      logic [1:0] o;
      @(negedge clk);
      load_i = ld; adv_n_i = advn; addr_i = a; seq_sel_i = mode;
      if (ld) begin
         m_start = a[1:0]; m_beat = 2'd0; m_upper = a[AW-1:2];
      end else if (!advn) begin
         m_beat = m_beat + 2'd1;
      end
      o = mode ? (m_start ^ m_beat) : (m_start + m_beat);
      e.ofs = o; e.full = {m_upper, o}; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: compare just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, e.ofs, e.full);
         end
      end
   end

   initial begin
      #1_000_000;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 check("R1 in reset", 2'b00, '0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #2 check("R1 after release", 2'b00, '0);

      // Full bursts from every start in both orders; addr_i noise tests R8
      for (int md = 1; md >= 0; md--) begin
         for (int s = 0; s < 4; s++) begin
            drive(1'b1, 1'b1, {15'(s * 4099 + md * 77 + 5), 2'(s)}, 1'(md), "R2 load");
            for (int k = 1; k <= 4; k++) begin
               drive(1'b0, 1'b0, AW'(k * 9311 + s),  1'(md),
                     (k == 4) ? "R6 wrap" : (md != 0 ? "R3 interleave R8" : "R4 linear R8"));
            end
         end
      end

      // Suspend: hold with advance released
      drive(1'b1, 1'b1, {15'h1234, 2'b10}, 1'b1, "R2 load");
      drive(1'b0, 1'b0, '0, 1'b1, "R3 step");
      for (int h = 0; h < 3; h++) drive(1'b0, 1'b1, AW'(h + 3), 1'b1, "R5 hold");
      drive(1'b0, 1'b0, '0, 1'b1, "R3 resume");

      // Load and advance in the same edge
      drive(1'b1, 1'b0, {15'h0abc, 2'b01}, 1'b0, "R7 load wins");
      drive(1'b0, 1'b0, '0, 1'b0, "R4 step");

      // Reload mid-burst
      drive(1'b0, 1'b0, '0, 1'b0, "R4 step");
      drive(1'b1, 1'b1, {15'h7001, 2'b11}, 1'b0, "R9 reload");
      drive(1'b0, 1'b0, '0, 1'b0, "R9 restart beat1");
      drive(1'b0, 1'b0, '0, 1'b0, "R9 restart beat2");
      drive(1'b1, 1'b1, {15'h2222, 2'b01}, 1'b1, "R9 reload interleave");
      drive(1'b0, 1'b0, '0, 1'b1, "R9 interleave beat1");

      @(negedge clk);
      load_i = 1'b0; adv_n_i = 1'b1;
      repeat (3) @(posedge clk);
      #3;
      if (sb_q.size() != 0) begin
         errors++; checks++;
         $display("FAIL scoreboard: %0d left, expected 0", sb_q.size());
      end
      report();
   end
endmodule